// File: doc/BRIEF.md
# Register Slave for AXI4-Lite with Access Enforcement

This block lets an AXI4-Lite bus master reach six 32-bit register words that sit at fixed word offsets above a base address set by a parameter. Each word has one access class. Read-write words are held in the slave and driven out to user logic. Read-only words come from user-logic inputs. A write-only word is held and driven out but cannot be read back. An access that breaks the word's class, or that falls outside the mapped window, is answered with SLVERR. Legal accesses are answered with OKAY. Two notification outputs give user logic a one-clock pulse. One fires when the bus completes a legal write to the control word. The other fires when the bus reads the status word.

The word map is as follows. Offset 0x00 is the control word (read-write, write pulse). Offset 0x04 is the status input (read-only, read pulse). Offset 0x08 is the transmit word (write-only). Offset 0x0C is the receive input (read-only). Offsets 0x10 and 0x14 hold a 64-bit read-write limit value, with the low 32 bits at 0x10 and the high 32 bits at 0x14. When the crossing option is enabled, the values driven out are re-registered through a chain of SYNC_STAGES flip-flops clocked by `mod_clk`. The status and receive inputs pass through a chain of the same depth clocked by the bus clock.

The write path runs a four-state machine. WR_IDLE goes to WR_RESP when address and data are accepted in the same cycle. It goes to WR_HAVE_ADDR when only the address is accepted, and to WR_HAVE_DATA when only the data is accepted. WR_HAVE_ADDR goes to WR_RESP when the data is accepted. WR_HAVE_DATA goes to WR_RESP when the address is accepted. WR_RESP goes back to WR_IDLE when BREADY is high. The write commits on the edge where the machine enters WR_RESP.

The read path has two states. RD_IDLE goes to RD_RESP when an address is accepted. RD_RESP goes back to RD_IDLE when RREADY is high.

Top module: `regslv_top`

## Requirements
- R1: The write-address and write-data channels are accepted independently and in either order, or in the same cycle. A write takes effect, and BVALID rises, only on the clock edge where the later of the two is captured.
- R2: A write to a read-only word (0x04, 0x0C) changes no register, gives no write pulse, and returns BRESP = 2'b10 (SLVERR).
- R3: A read of the write-only word (0x08) returns RRESP = 2'b10 and RDATA = 0.
- R4: WSTRB bit i gates byte lane i (bits 8i+7..8i) of the addressed word. Lanes whose strobe bit is low keep their value, so a write with WSTRB = 0 changes nothing.
- R5: A legal write to the control word (0x00) drives `ctrl_wr_pulse` high for exactly one clock, in the cycle in which BVALID rises.
- R6: A read of the status word (0x04) drives `status_rd_pulse` high for exactly one clock, in the cycle in which RVALID rises. RDATA carries the status input as sampled on the accepting edge. Reads of other words give no pulse.
- R7: While `rst_n` is low at a bus clock edge, the following reset values load: control to CTRL_RST, transmit to 0, and the 64-bit limit to WIDE_RST. BVALID and RVALID clear, and AWREADY, WREADY and ARREADY are high once reset is released.
- R8: Offsets are taken relative to BASE_ADDR. Legal accesses return 2'b00 (OKAY). A read of a read-write word returns the value last written.
- R9: The 64-bit limit value is written and read as two words: bits 31..0 at offset 0x10 and bits 63..32 at offset 0x14.
- R10: Any address outside BASE_ADDR .. BASE_ADDR+0x17, including addresses below the base, returns SLVERR. Reads of such addresses return RDATA = 0, and writes to them change nothing.
- R11: BVALID and RVALID stay high, with their response and data held, until BREADY or RREADY is seen. AWREADY and WREADY are low while a write response is pending. ARREADY is low while a read response is pending.
- R12: With CDC_EN = 1, each output word follows its bus-side register after SYNC_STAGES edges of `mod_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane enables |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read response valid |
| rready | input | 1 | Read response accepted |
| mod_clk | input | 1 | User-logic clock for the crossing chains |
| ctrl_out | output | 32 | Control word toward user logic |
| ctrl_wr_pulse | output | 1 | One-clock pulse on a legal control write |
| status_in | input | 32 | Status word from user logic |
| status_rd_pulse | output | 1 | One-clock pulse on a status read |
| txd_out | output | 32 | Transmit word toward user logic |
| rxd_in | input | 32 | Receive word from user logic |
| wide_out | output | 64 | 64-bit limit value toward user logic |

## Verification
The assertions assume that the master keeps BREADY and RREADY free of X, and that `rst_n` is only released between transactions. Under those assumptions, the hold and blocking properties follow only from the machines' handshakes. The read-pulse and SLVERR-data properties also assume the status input is steady from the accepting edge until the response is seen. The stimulus meets these assumptions in three ways. It changes every input only on falling edges. It raises each valid only while the matching ready is known to be high and drops it right after the accepting edge. It changes the status and receive inputs only while no read is in flight.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    localparam int DATA_W    = 32;
    localparam int STRB_W    = DATA_W / 8;
    localparam int NUM_WORDS = 6;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    // word indices; offset = index * 4
    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_TXD  = 2;
    localparam int IDX_RXD  = 3;
    localparam int IDX_WLO  = 4;
    localparam int IDX_WHI  = 5;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef enum logic [1:0] {
        MODE_RW,
        MODE_RO,
        MODE_WO,
        MODE_NONE
    } acc_mode_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_HAVE_ADDR,
        WR_HAVE_DATA,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } decode_t;

    function automatic acc_mode_e mode_of(input int idx);
        case (idx)
            IDX_CTRL, IDX_WLO, IDX_WHI: return MODE_RW;
            IDX_STAT, IDX_RXD:          return MODE_RO;
            IDX_TXD:                    return MODE_WO;
            default:                    return MODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/regslv_sync.sv
module regslv_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2,
    parameter bit EN     = 1'b1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
        end
    end

    // the chain is always built; the parameter picks its output or a bypass
    assign q = EN ? stg[STAGES-1] : d;

endmodule

// File: rtl/regslv_wr_fsm.sv
module regslv_wr_fsm
    import regslv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  awaddr,
    input  logic               awvalid,
    output logic               awready,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [STRB_W-1:0]  wstrb,
    input  logic               wvalid,
    output logic               wready,
    output logic [1:0]         bresp,
    output logic               bvalid,
    input  logic               bready,
    output logic               commit,
    output logic [ADDR_W-1:0]  commit_addr,
    output logic [DATA_W-1:0]  commit_data,
    output logic [STRB_W-1:0]  commit_strb,
    input  logic               commit_err
);

    wr_state_e           state, state_nx;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [STRB_W-1:0]   strb_q;
    logic [1:0]          bresp_q;
    logic                aw_hs, w_hs;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE: begin
                if (aw_hs && w_hs)  state_nx = WR_RESP;
                else if (aw_hs)     state_nx = WR_HAVE_ADDR;
                else if (w_hs)      state_nx = WR_HAVE_DATA;
            end
            WR_HAVE_ADDR: if (w_hs)   state_nx = WR_RESP;
            WR_HAVE_DATA: if (aw_hs)  state_nx = WR_RESP;
            WR_RESP:      if (bready) state_nx = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready     = (state == WR_IDLE) || (state == WR_HAVE_DATA);
        wready      = (state == WR_IDLE) || (state == WR_HAVE_ADDR);
        bvalid      = (state == WR_RESP);
        bresp       = bresp_q;
        aw_hs       = awvalid && awready;
        w_hs        = wvalid && wready;
        commit      = (state != WR_RESP) && (state_nx == WR_RESP);
        commit_addr = aw_hs ? awaddr : addr_q;
        commit_data = w_hs ? wdata : data_q;
        commit_strb = w_hs ? wstrb : strb_q;
    end

    // channel capture and response code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            strb_q  <= '0;
            bresp_q <= RESP_OKAY;
        end else begin
            if (aw_hs) addr_q <= awaddr;
            if (w_hs) begin
                data_q <= wdata;
                strb_q <= wstrb;
            end
            if (commit) bresp_q <= commit_err ? RESP_SLVERR : RESP_OKAY;
        end
    end

endmodule

// File: rtl/regslv_rd_fsm.sv
module regslv_rd_fsm
    import regslv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic               arvalid,
    output logic               arready,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    output logic               rvalid,
    input  logic               rready,
    output logic               accept,
    output logic [ADDR_W-1:0]  accept_addr,
    input  logic [DATA_W-1:0]  lookup_data,
    input  logic               lookup_err
);

    rd_state_e          state, state_nx;
    logic [DATA_W-1:0]  rdata_q;
    logic [1:0]         rresp_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: if (arvalid) state_nx = RD_RESP;
            RD_RESP: if (rready)  state_nx = RD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        arready     = (state == RD_IDLE);
        rvalid      = (state == RD_RESP);
        rdata       = rdata_q;
        rresp       = rresp_q;
        accept      = arvalid && arready;
        accept_addr = araddr;
    end

    // response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rresp_q <= RESP_OKAY;
        end else if (accept) begin
            rdata_q <= lookup_data;
            rresp_q <= lookup_err ? RESP_SLVERR : RESP_OKAY;
        end
    end

endmodule

// File: rtl/regslv_bank.sv
module regslv_bank
    import regslv_pkg::*;
#(
    parameter int                  ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]   BASE_ADDR = '0,
    parameter logic [DATA_W-1:0]   CTRL_RST  = '0,
    parameter logic [2*DATA_W-1:0] WIDE_RST  = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_go,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [STRB_W-1:0]   wr_strb,
    output logic                wr_err,
    input  logic                rd_go,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_err,
    input  logic [DATA_W-1:0]   status_val,
    input  logic [DATA_W-1:0]   rxd_val,
    output logic [DATA_W-1:0]   ctrl_q,
    output logic [DATA_W-1:0]   txd_q,
    output logic [2*DATA_W-1:0] wide_q,
    output logic                ctrl_wr_pulse,
    output logic                status_rd_pulse
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS * STRB_W);

    function automatic decode_t decode(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        decode_t r;
        off   = a - BASE_ADDR;
        r.hit = (off < SPAN);
        r.idx = off[IDX_W+1:2];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] reset_of(input int idx);
        case (idx)
            IDX_CTRL: return CTRL_RST;
            IDX_WLO:  return WIDE_RST[DATA_W-1:0];
            IDX_WHI:  return WIDE_RST[2*DATA_W-1:DATA_W];
            default:  return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                                input logic [DATA_W-1:0] new_v,
                                                input logic [STRB_W-1:0] en);
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int l = 0; l < STRB_W; l++) begin
            if (en[l]) r[8*l +: 8] = new_v[8*l +: 8];
        end
        return r;
    endfunction

    decode_t            wr_dec, rd_dec;
    acc_mode_e          wr_mode, rd_mode;
    logic [DATA_W-1:0]  word_q [NUM_WORDS];

    always_comb begin
        wr_dec  = decode(wr_addr);
        rd_dec  = decode(rd_addr);
        wr_mode = wr_dec.hit ? mode_of(int'(wr_dec.idx)) : MODE_NONE;
        rd_mode = rd_dec.hit ? mode_of(int'(rd_dec.idx)) : MODE_NONE;
        wr_err  = (wr_mode == MODE_RO) || (wr_mode == MODE_NONE);
        rd_err  = (rd_mode == MODE_WO) || (rd_mode == MODE_NONE);
        rd_data = '0;
        if (!rd_err) rd_data = word_q[rd_dec.idx];
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (mode_of(g) == MODE_RW || mode_of(g) == MODE_WO) begin : g_store
            localparam logic [DATA_W-1:0] RST_V = reset_of(g);
            logic [DATA_W-1:0] q;
            logic              sel;
            assign sel = wr_go && !wr_err && (wr_dec.idx == IDX_W'(g));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= RST_V;
                end else if (sel) begin
                    q <= merge(q, wr_data, wr_strb);
                end
            end
            assign word_q[g] = q;
        end else begin : g_input
            assign word_q[g] = (g == IDX_STAT) ? status_val : rxd_val;
        end
    end

    assign ctrl_q = word_q[IDX_CTRL];
    assign txd_q  = word_q[IDX_TXD];
    assign wide_q = {word_q[IDX_WHI], word_q[IDX_WLO]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_wr_pulse   <= 1'b0;
            status_rd_pulse <= 1'b0;
        end else begin
            ctrl_wr_pulse   <= wr_go && !wr_err && (wr_dec.idx == IDX_W'(IDX_CTRL));
            status_rd_pulse <= rd_go && !rd_err && (rd_dec.idx == IDX_W'(IDX_STAT));
        end
    end

endmodule

// File: rtl/regslv_top.sv
module regslv_top
    import regslv_pkg::*;
#(
    parameter int                  ADDR_W      = 32,
    parameter logic [ADDR_W-1:0]   BASE_ADDR   = 32'h4000_0000,
    parameter logic [DATA_W-1:0]   CTRL_RST    = 32'h0000_0A01,
    parameter logic [2*DATA_W-1:0] WIDE_RST    = 64'hFFFF_FFFF_0000_0000,
    parameter bit                  CDC_EN      = 1'b0,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [STRB_W-1:0]   wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready,
    input  logic                mod_clk,
    output logic [DATA_W-1:0]   ctrl_out,
    output logic                ctrl_wr_pulse,
    input  logic [DATA_W-1:0]   status_in,
    output logic                status_rd_pulse,
    output logic [DATA_W-1:0]   txd_out,
    input  logic [DATA_W-1:0]   rxd_in,
    output logic [2*DATA_W-1:0] wide_out
);

    logic                commit, commit_err;
    logic [ADDR_W-1:0]   commit_addr;
    logic [DATA_W-1:0]   commit_data;
    logic [STRB_W-1:0]   commit_strb;
    logic                accept, lookup_err;
    logic [ADDR_W-1:0]   accept_addr;
    logic [DATA_W-1:0]   lookup_data;
    logic [DATA_W-1:0]   status_val, rxd_val;
    logic [DATA_W-1:0]   ctrl_q, txd_q;
    logic [2*DATA_W-1:0] wide_q;

    regslv_wr_fsm #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
        .commit_strb(commit_strb), .commit_err(commit_err)
    );

    regslv_rd_fsm #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .accept(accept), .accept_addr(accept_addr),
        .lookup_data(lookup_data), .lookup_err(lookup_err)
    );

    regslv_bank #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .CTRL_RST(CTRL_RST), .WIDE_RST(WIDE_RST)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_go(commit), .wr_addr(commit_addr), .wr_data(commit_data),
        .wr_strb(commit_strb), .wr_err(commit_err),
        .rd_go(accept), .rd_addr(accept_addr), .rd_data(lookup_data),
        .rd_err(lookup_err),
        .status_val(status_val), .rxd_val(rxd_val),
        .ctrl_q(ctrl_q), .txd_q(txd_q), .wide_q(wide_q),
        .ctrl_wr_pulse(ctrl_wr_pulse), .status_rd_pulse(status_rd_pulse)
    );

    // toward the module clock
    regslv_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .EN(CDC_EN)) u_sync_ctrl (
        .clk(mod_clk), .d(ctrl_q), .q(ctrl_out)
    );
    regslv_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .EN(CDC_EN)) u_sync_txd (
        .clk(mod_clk), .d(txd_q), .q(txd_out)
    );
    regslv_sync #(.W(2*DATA_W), .STAGES(SYNC_STAGES), .EN(CDC_EN)) u_sync_wide (
        .clk(mod_clk), .d(wide_q), .q(wide_out)
    );

    // from the module clock into the bus clock
    regslv_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .EN(CDC_EN)) u_sync_stat (
        .clk(clk), .d(status_in), .q(status_val)
    );
    regslv_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .EN(CDC_EN)) u_sync_rxd (
        .clk(clk), .d(rxd_in), .q(rxd_val)
    );

endmodule

// File: rtl/regslv_chk.sv
module regslv_chk
    import regslv_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                awready,
    input logic                wready,
    input logic [1:0]          bresp,
    input logic                bvalid,
    input logic                bready,
    input logic                arready,
    input logic [DATA_W-1:0]   rdata,
    input logic [1:0]          rresp,
    input logic                rvalid,
    input logic                rready,
    input logic                ctrl_wr_pulse,
    input logic                status_rd_pulse,
    input logic [DATA_W-1:0]   ctrl_reg,
    input logic [DATA_W-1:0]   txd_reg,
    input logic [2*DATA_W-1:0] wide_reg
);

    // R11
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid && $stable(bresp));

    // R11
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));

    // R11
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready && !wready);

    // R11
    rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

    // R5
    ctrl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_pulse |-> $rose(bvalid) && (bresp == RESP_OKAY));

    // R5
    ctrl_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_pulse |=> !ctrl_wr_pulse);

    // R6
    stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd_pulse |-> $rose(rvalid) && (rresp == RESP_OKAY));

    // R2
    ro_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bvalid) && (bresp == RESP_SLVERR)
            |-> $stable(ctrl_reg) && $stable(txd_reg) && $stable(wide_reg) && !ctrl_wr_pulse);

    // R3
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && (rresp == RESP_SLVERR) |-> (rdata == '0));

    // R8
    resp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == RESP_OKAY) || (bresp == RESP_SLVERR));

endmodule

bind regslv_top regslv_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .awready(awready), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .arready(arready), .rdata(rdata), .rresp(rresp),
    .rvalid(rvalid), .rready(rready),
    .ctrl_wr_pulse(ctrl_wr_pulse), .status_rd_pulse(status_rd_pulse),
    .ctrl_reg(ctrl_q), .txd_reg(txd_q), .wide_reg(wide_q)
);

// File: tb/tb_regslv_top.sv
module tb_regslv_top;

    localparam logic [31:0] BASE      = 32'h4000_0000;
    localparam logic [31:0] CTRL_DEF  = 32'h0000_0A01;
    localparam logic [63:0] WIDE_DEF  = 64'hFFFF_FFFF_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] awaddr = '0, wdata = '0, araddr = '0;
    logic [3:0]  wstrb = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
    logic        arvalid = 1'b0, rready = 1'b0;
    logic [31:0] st_in = '0, rx_in = '0;

    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata, ctrl_out, txd_out;
    logic [63:0] wide_out;
    logic        ctrl_wr_pulse, status_rd_pulse;

    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata, s_ctrl_out, s_txd_out;
    logic [63:0] s_wide_out;
    logic        s_ctrl_pulse, s_stat_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    int since_rst = 0;

    // reference model state
    logic [31:0] m_ctrl = CTRL_DEF;
    logic [31:0] m_txd  = '0;
    logic [63:0] m_wide = WIDE_DEF;
    logic [31:0] h1 = CTRL_DEF, h2 = CTRL_DEF;

    always #5 clk = ~clk;

    regslv_top dut (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .mod_clk(clk),
        .ctrl_out(ctrl_out), .ctrl_wr_pulse(ctrl_wr_pulse),
        .status_in(st_in), .status_rd_pulse(status_rd_pulse),
        .txd_out(txd_out), .rxd_in(rx_in), .wide_out(wide_out)
    );

    regslv_top #(.CDC_EN(1'b1), .SYNC_STAGES(2)) dut_sync (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(s_awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(rready),
        .mod_clk(clk),
        .ctrl_out(s_ctrl_out), .ctrl_wr_pulse(s_ctrl_pulse),
        .status_in(st_in), .status_rd_pulse(s_stat_pulse),
        .txd_out(s_txd_out), .rxd_in(rx_in), .wide_out(s_wide_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // word index from the map, -1 when outside the window
    function automatic int idx_of(input logic [31:0] a);
        logic [31:0] off;
        off = a - BASE;
        if (off >= 32'd24) return -1;
        return int'(off >> 2);
    endfunction

    // 0 = read-write, 1 = read-only, 2 = write-only, 3 = unmapped
    function automatic int class_of(input int ix);
        case (ix)
            0, 4, 5: return 0;
            1, 3:    return 1;
            2:       return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] s);
        logic [31:0] r;
        r = o;
        for (int l = 0; l < 4; l++) if (s[l]) r[8*l +: 8] = n[8*l +: 8];
        return r;
    endfunction

    // every-clock comparison of the output words against the model
    always @(negedge clk) begin
        if (!rst_n) since_rst <= 0;
        else since_rst <= since_rst + 1;
        if (rst_n && started) begin
            chk("R8 ctrl_out", {32'h0, ctrl_out}, {32'h0, m_ctrl});
            chk("R8 txd_out",  {32'h0, txd_out},  {32'h0, m_txd});
            chk("R9 wide_out", wide_out, m_wide);
            if (since_rst >= 3) chk("R12 synced ctrl_out", {32'h0, s_ctrl_out}, {32'h0, h2});
        end
        h2 <= h1;
        h1 <= m_ctrl;
    end

    // mode 0: both channels together, 1: address first, 2: data first
    task automatic wr(input int mode, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] s, input string req);
        int  ix;
        bit  err;
        ix  = idx_of(a);
        err = (class_of(ix) == 1) || (class_of(ix) == 3);
        @(negedge clk);
        if (mode == 1) begin
            awaddr = a; awvalid = 1'b1;
            @(negedge clk);
            awvalid = 1'b0;
            chk({req, " R1 no resp after addr only"}, {63'h0, bvalid}, 64'h0);
            chk({req, " R1 awready low, waiting data"}, {63'h0, awready}, 64'h0);
            chk({req, " R1 wready high, waiting data"}, {63'h0, wready}, 64'h1);
            wdata = d; wstrb = s; wvalid = 1'b1;
        end else if (mode == 2) begin
            wdata = d; wstrb = s; wvalid = 1'b1;
            @(negedge clk);
            wvalid = 1'b0;
            chk({req, " R1 no resp after data only"}, {63'h0, bvalid}, 64'h0);
            chk({req, " R1 wready low, waiting addr"}, {63'h0, wready}, 64'h0);
            awaddr = a; awvalid = 1'b1;
        end else begin
            awaddr = a; awvalid = 1'b1;
            wdata = d; wstrb = s; wvalid = 1'b1;
        end
        @(posedge clk);
        #1;
        if (!err) begin
            case (ix)
                0: m_ctrl = lanes(m_ctrl, d, s);
                2: m_txd = lanes(m_txd, d, s);
                4: m_wide[31:0] = lanes(m_wide[31:0], d, s);
                5: m_wide[63:32] = lanes(m_wide[63:32], d, s);
                default: ;
            endcase
        end
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        chk({req, " R1 bvalid up"}, {63'h0, bvalid}, 64'h1);
        chk({req, " R2/R8/R10 bresp"}, {62'h0, bresp}, err ? 64'h2 : 64'h0);
        chk({req, " R5 ctrl pulse"}, {63'h0, ctrl_wr_pulse}, (ix == 0 && !err) ? 64'h1 : 64'h0);
        chk({req, " R11 awready blocked"}, {62'h0, awready, wready}, 64'h0);
        @(negedge clk);
        chk({req, " R11 bvalid held"}, {63'h0, bvalid}, 64'h1);
        chk({req, " R11 bresp held"}, {62'h0, bresp}, err ? 64'h2 : 64'h0);
        chk({req, " R5 pulse one clock"}, {63'h0, ctrl_wr_pulse}, 64'h0);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        chk({req, " R11 bvalid released"}, {63'h0, bvalid}, 64'h0);
        chk({req, " R11 awready back"}, {63'h0, awready}, 64'h1);
    endtask

    task automatic rd(input logic [31:0] a, input string req);
        int          ix, cl;
        logic [31:0] ed;
        bit          err;
        ix  = idx_of(a);
        cl  = class_of(ix);
        err = (cl == 2) || (cl == 3);
        case (ix)
            0:       ed = m_ctrl;
            1:       ed = st_in;
            3:       ed = rx_in;
            4:       ed = m_wide[31:0];
            5:       ed = m_wide[63:32];
            default: ed = '0;
        endcase
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        chk({req, " R11 rvalid up"}, {63'h0, rvalid}, 64'h1);
        chk({req, " R3/R8/R10 rdata"}, {32'h0, rdata}, {32'h0, ed});
        chk({req, " R3/R8/R10 rresp"}, {62'h0, rresp}, err ? 64'h2 : 64'h0);
        chk({req, " R6 status pulse"}, {63'h0, status_rd_pulse}, (ix == 1) ? 64'h1 : 64'h0);
        chk({req, " R11 arready blocked"}, {63'h0, arready}, 64'h0);
        @(negedge clk);
        chk({req, " R11 rvalid held"}, {63'h0, rvalid}, 64'h1);
        chk({req, " R11 rdata held"}, {32'h0, rdata}, {32'h0, ed});
        chk({req, " R6 pulse one clock"}, {63'h0, status_rd_pulse}, 64'h0);
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        chk({req, " R11 rvalid released"}, {63'h0, rvalid}, 64'h0);
        chk({req, " R11 arready back"}, {63'h0, arready}, 64'h1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        m_ctrl = CTRL_DEF;
        m_txd  = '0;
        m_wide = WIDE_DEF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R7 awready after reset", {63'h0, awready}, 64'h1);
        chk("R7 wready after reset", {63'h0, wready}, 64'h1);
        chk("R7 arready after reset", {63'h0, arready}, 64'h1);
        chk("R7 no responses after reset", {62'h0, bvalid, rvalid}, 64'h0);
        chk("R7 ctrl default", {32'h0, ctrl_out}, {32'h0, CTRL_DEF});
        chk("R7 txd default", {32'h0, txd_out}, 64'h0);
        chk("R7 wide default", wide_out, WIDE_DEF);
    endtask

    initial begin
        do_reset();
        started = 1'b1;
        rd(BASE + 32'h00, "R7 ctrl default readback");

        wr(0, BASE + 32'h00, 32'h1234_5678, 4'hF, "R5 ctrl write");
        rd(BASE + 32'h00, "R8 ctrl readback");
        wr(1, BASE + 32'h00, 32'hAABB_CCDD, 4'b0101, "R4 lanes 0 and 2, addr first");
        rd(BASE + 32'h00, "R4 ctrl merged");
        wr(2, BASE + 32'h08, 32'hCAFE_F00D, 4'hF, "R1 txd data first");
        rd(BASE + 32'h08, "R3 write-only read");
        wr(0, BASE + 32'h04, 32'hFFFF_FFFF, 4'hF, "R2 status write");
        wr(1, BASE + 32'h0C, 32'h0000_0001, 4'hF, "R2 rxd write");
        wr(2, BASE + 32'h00, 32'hFFFF_FFFF, 4'h0, "R4 empty strobe");
        rd(BASE + 32'h00, "R4 ctrl unchanged");

        st_in = 32'h5A5A_0001;
        rd(BASE + 32'h04, "R6 status read");
        st_in = 32'h0000_00F0;
        rd(BASE + 32'h04, "R6 second status read");
        rx_in = 32'h0BAD_BEEF;
        rd(BASE + 32'h0C, "R8 rxd read");

        wr(0, BASE + 32'h10, 32'h1111_2222, 4'hF, "R9 low word");
        wr(1, BASE + 32'h14, 32'h9900_0000, 4'b1000, "R9 high byte");
        rd(BASE + 32'h10, "R9 low readback");
        rd(BASE + 32'h14, "R9 high readback");

        wr(0, BASE + 32'h18, 32'hDEAD_0000, 4'hF, "R10 write past window");
        wr(2, BASE - 32'h4, 32'hDEAD_0001, 4'hF, "R10 write below base");
        rd(BASE + 32'h40, "R10 read past window");
        rd(BASE - 32'h4, "R10 read below base");

        wr(0, BASE + 32'h00, 32'h0000_00C3, 4'b0001, "R5 back-to-back write");
        do_reset();
        rd(BASE + 32'h00, "R7 ctrl after second reset");
        rd(BASE + 32'h14, "R7 wide high after reset");
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule